// File: doc/BRIEF.md
# Backscatter Subcarrier Period Synthesizer

This block produces the reply subcarrier of a passive tag. It takes the calibration length that the receiver measured, as a count of whole clock cycles, and a divide-ratio choice. From these it derives how many clock cycles one subcarrier period lasts, and then plays that period out for as long as the reply is enabled. It does not drive the modulator line itself. Each clock cycle it emits a 2-bit select code for an external four-input multiplexer. The code values are 00 for constant low, 01 for constant high, 10 for the clock itself and 11 for the inverted clock.

Three shaping modes are offered. The balanced mode rounds the half period and repeats it twice. The unbalanced mode rounds the full period and gives the high phase the extra cycle when the count is odd. The half-clock mode also rounds the full period. When the period is odd, it spends one cycle on the clock source, which places a mid-cycle falling transition so that high and low time stay equal to half a cycle. A one-cycle strobe marks the start of every period. The period values are captured when enable rises and stay fixed for the whole reply.

Top module: `blf_synth_top`

## Requirements
- R1: While reset is asserted, and after reset until enable first rises, the select output is 00 (constant low) and the strobe is 0.
- R2: Whenever enable is sampled low at a clock edge, select is 00 and strobe is 0 in the following cycle, whatever the other inputs are.
- R3: With dr_sel = 0 (ratio 8), the full period is t = floor((n+4)/8) and the half period is h = floor((n+8)/16), where n is the calibration count.
- R4: With dr_sel = 1 (ratio 64/3), the full period is t = floor((3n+32)/64) and the half period is h = floor((3n+64)/128).
- R5: In balanced mode (mode 00, and also mode 11), each period is h cycles of code 01 followed by h cycles of code 00. If h is 0 it is treated as 1.
- R6: In unbalanced mode (mode 01), each period lasts t cycles: ceil(t/2) cycles of code 01, then floor(t/2) cycles of code 00.
- R7: In half-clock mode (mode 10), each period lasts t cycles. It is floor(t/2) cycles of code 01, then one cycle of code 10 only when t is odd, then floor(t/2) cycles of code 00. Code 11 is never emitted.
- R8: The strobe is high for exactly the first cycle of every period, which is always a code 01 cycle, and low otherwise.
- R9: The calibration count, ratio and mode are captured at the edge where enable is first sampled high. Changing them while enable stays high has no effect on the waveform.
- R10: In modes 01 and 10, a full period below 2 is raised to 2.
- R11: The first period starts in the cycle right after the edge that samples enable rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Reply enable; its rising edge captures the settings |
| trcal_cnt | input | CNT_W | Measured calibration length in whole clock cycles |
| dr_sel | input | 1 | Divide ratio: 0 = 8, 1 = 64/3 |
| mode | input | 2 | 00 balanced, 01 unbalanced, 10 half-clock, 11 balanced |
| sel | output | 2 | Multiplexer select: 00 low, 01 high, 10 clk, 11 inverted clk |
| period_stb | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The main function is driven with calibration counts that give even and odd full periods in each mode, for both ratios. This separates the three rounding schemes: an odd count shows the extra high cycle in unbalanced mode and the clock-select cycle in half-clock mode, while balanced mode never produces an odd period. Very small counts drive the minimum-period clamps, and mode 11 shows that it falls back to balanced. Random runs change the count, ratio and mode halfway through a reply, so a design that re-reads its inputs instead of holding the captured values produces a visibly different period.

// File: rtl/blf_pkg.sv
package blf_pkg;

  typedef enum logic [1:0] {
    MODE_BAL     = 2'b00,
    MODE_UNBAL   = 2'b01,
    MODE_HALF    = 2'b10,
    MODE_BAL_ALT = 2'b11
  } blf_mode_e;

  localparam logic [1:0] SEL_LOW  = 2'b00;
  localparam logic [1:0] SEL_HIGH = 2'b01;
  localparam logic [1:0] SEL_CLK  = 2'b10;
  localparam logic [1:0] SEL_NCLK = 2'b11;

endpackage

// File: rtl/blf_scale.sv
// Rounded division of the calibration count by the divide ratio,
// or by twice the ratio when HALF = 1.
module blf_scale #(
  parameter int CNT_W = 12,
  parameter int OUT_W = 10,
  parameter int HALF  = 0
) (
  input  logic [CNT_W-1:0] trcal_i,
  input  logic             dr_sel_i,
  output logic [OUT_W-1:0] q_o
);

  localparam int EXT_W   = CNT_W + 3;
  localparam int SH_D8   = 3 + HALF;
  localparam int SH_D21  = 6 + HALF;
  localparam int RND_D8  = 4 << HALF;
  localparam int RND_D21 = 32 << HALF;

  logic [EXT_W-1:0] n_ext;
  logic [EXT_W-1:0] sum_d8;
  logic [EXT_W-1:0] sum_d21;
  logic [EXT_W-1:0] quo_d8;
  logic [EXT_W-1:0] quo_d21;

  always_comb begin
    n_ext   = EXT_W'(trcal_i);
    sum_d8  = n_ext + EXT_W'(RND_D8);
    sum_d21 = (n_ext << 1) + n_ext + EXT_W'(RND_D21);
    quo_d8  = sum_d8 >> SH_D8;
    quo_d21 = sum_d21 >> SH_D21;
    q_o     = dr_sel_i ? OUT_W'(quo_d21) : OUT_W'(quo_d8);
  end

endmodule

// File: rtl/blf_period_calc.sv
// Derives period length and high-phase length for the selected mode.
module blf_period_calc
  import blf_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PER_W = CNT_W - 2
) (
  input  logic [CNT_W-1:0] trcal_i,
  input  logic             dr_sel_i,
  input  blf_mode_e        mode_i,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] hi_o
);

  localparam int NUM_SCALE = 2;

  logic [PER_W-1:0] scaled [NUM_SCALE];
  logic [PER_W-1:0] full_c;
  logic [PER_W-1:0] half_c;
  logic [PER_W:0]   full_p1;

  // index 0: full period, index 1: half period
  for (genvar g = 0; g < NUM_SCALE; g++) begin : g_scale
    blf_scale #(
      .CNT_W(CNT_W),
      .OUT_W(PER_W),
      .HALF (g)
    ) u_scale (
      .trcal_i (trcal_i),
      .dr_sel_i(dr_sel_i),
      .q_o     (scaled[g])
    );
  end

  always_comb begin
    full_c  = (scaled[0] < PER_W'(2)) ? PER_W'(2) : scaled[0];
    half_c  = (scaled[1] == '0) ? PER_W'(1) : scaled[1];
    full_p1 = {1'b0, full_c} + (PER_W+1)'(1);
    unique case (mode_i)
      MODE_UNBAL: begin
        per_o = full_c;
        hi_o  = full_p1[PER_W:1];
      end
      MODE_HALF: begin
        per_o = full_c;
        hi_o  = full_c >> 1;
      end
      default: begin
        per_o = half_c << 1;
        hi_o  = half_c;
      end
    endcase
  end

endmodule

// File: rtl/blf_phase_ctrl.sv
// Captures settings on enable rise and steps the in-period position.
module blf_phase_ctrl
  import blf_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] hi_i,
  input  blf_mode_e        mode_i,
  output logic             active_o,
  output logic [PER_W-1:0] pos_o,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] hi_o,
  output blf_mode_e        mode_o
);

  logic             en_q, en_d;
  logic [PER_W-1:0] pos_q, pos_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] hi_q, hi_d;
  blf_mode_e        mode_q, mode_d;
  logic             load;
  logic             wrap;

  always_comb begin
    load   = en_i & ~en_q;
    wrap   = (pos_q == per_q - PER_W'(1));
    en_d   = en_i;
    per_d  = per_q;
    hi_d   = hi_q;
    mode_d = mode_q;
    pos_d  = '0;
    if (load) begin
      per_d  = per_i;
      hi_d   = hi_i;
      mode_d = mode_i;
    end else if (en_i && en_q) begin
      pos_d = wrap ? '0 : pos_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pos_q  <= '0;
      per_q  <= PER_W'(2);
      hi_q   <= PER_W'(1);
      mode_q <= MODE_BAL;
    end else begin
      en_q  <= en_d;
      pos_q <= pos_d;
      if (load) begin
        per_q  <= per_d;
        hi_q   <= hi_d;
        mode_q <= mode_d;
      end
    end
  end

  assign active_o = en_q;
  assign pos_o    = pos_q;
  assign per_o    = per_q;
  assign hi_o     = hi_q;
  assign mode_o   = mode_q;

  // R2: enable low at an edge leaves the block inactive afterwards
  a_r2_idle_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !en_q);

  // R9: captured values stay put while the reply continues
  a_r9_hold_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && en_i) |=> ($stable(per_q) && $stable(hi_q) && $stable(mode_q)));

  // R8: position never leaves the period
  a_r8_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (pos_q < per_q));

  // R10: period never shorter than two cycles
  a_r10_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (per_q >= PER_W'(2)));

endmodule

// File: rtl/blf_sel_gen.sv
// Maps the in-period position to a multiplexer select code and strobe.
module blf_sel_gen
  import blf_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [PER_W-1:0] pos_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] hi_i,
  input  blf_mode_e        mode_i,
  output logic [1:0]       sel_o,
  output logic             stb_o
);

  logic in_high;
  logic frag_cycle;

  always_comb begin
    in_high    = (pos_i < hi_i);
    frag_cycle = (mode_i == MODE_HALF) && per_i[0] && (pos_i == hi_i);
    stb_o      = active_i && (pos_i == '0);
    if (!active_i) begin
      sel_o = SEL_LOW;
    end else if (in_high) begin
      sel_o = SEL_HIGH;
    end else if (frag_cycle) begin
      sel_o = SEL_CLK;
    end else begin
      sel_o = SEL_LOW;
    end
  end

  // R8: strobe never lasts two cycles
  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);

  // R8: strobe coincides with a high cycle
  a_r8_stb_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> (sel_o == SEL_HIGH));

  // R7: inverted-clock code never produced
  a_r7_no_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o != SEL_NCLK);

  // R7: clock code only in half-clock mode
  a_r7_clk_half_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == SEL_CLK) |-> (mode_i == MODE_HALF));

endmodule

// File: rtl/blf_synth_top.sv
module blf_synth_top
  import blf_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] trcal_cnt,
  input  logic             dr_sel,
  input  logic [1:0]       mode,
  output logic [1:0]       sel,
  output logic             period_stb
);

  localparam int PER_W = CNT_W - 2;

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  blf_mode_e        mode_in;
  logic [PER_W-1:0] calc_per;
  logic [PER_W-1:0] calc_hi;
  logic             active;
  logic [PER_W-1:0] pos;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] hi_q;
  blf_mode_e        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];
  assign mode_in   = blf_mode_e'(mode);

  blf_period_calc #(
    .CNT_W(CNT_W),
    .PER_W(PER_W)
  ) u_calc (
    .trcal_i (trcal_cnt),
    .dr_sel_i(dr_sel),
    .mode_i  (mode_in),
    .per_o   (calc_per),
    .hi_o    (calc_hi)
  );

  blf_phase_ctrl #(
    .PER_W(PER_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en_i    (en),
    .per_i   (calc_per),
    .hi_i    (calc_hi),
    .mode_i  (mode_in),
    .active_o(active),
    .pos_o   (pos),
    .per_o   (per_q),
    .hi_o    (hi_q),
    .mode_o  (mode_q)
  );

  blf_sel_gen #(
    .PER_W(PER_W)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active_i(active),
    .pos_i   (pos),
    .per_i   (per_q),
    .hi_i    (hi_q),
    .mode_i  (mode_q),
    .sel_o   (sel),
    .stb_o   (period_stb)
  );

endmodule

// File: tb/blf_synth_top_tb_top.sv
`timescale 1ns/1ps
module blf_synth_top_tb_top;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en;
  logic [CNT_W-1:0] trc;
  logic             dr;
  logic [1:0]       mode;
  logic [1:0]       sel;
  logic             stb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  blf_synth_top #(.CNT_W(CNT_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .trcal_cnt (trc),
    .dr_sel    (dr),
    .mode      (mode),
    .sel       (sel),
    .period_stb(stb)
  );

  function automatic int e_full(input int d, input int n);
    return d ? (3 * n + 32) / 64 : (n + 4) / 8;
  endfunction

  function automatic int e_half(input int d, input int n);
    return d ? (3 * n + 64) / 128 : (n + 8) / 16;
  endfunction

  function automatic int e_per(input int m, input int d, input int n);
    int t, h;
    t = e_full(d, n);
    h = e_half(d, n);
    if (m == 1 || m == 2) return (t < 2) ? 2 : t;
    return 2 * ((h < 1) ? 1 : h);
  endfunction

  function automatic int e_hi(input int m, input int p);
    if (m == 1) return (p + 1) / 2;
    return p / 2;
  endfunction

  function automatic int e_sel(input int m, input int p, input int pos);
    int hi;
    hi = e_hi(m, p);
    if (pos < hi) return 1;
    if (m == 2 && (p % 2) == 1 && pos == hi) return 2;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m, input int d);
    string rt;
    rt = d ? "R4" : "R3";
    if (m == 1) return {rt, "/R6"};
    if (m == 2) return {rt, "/R7"};
    return {rt, "/R5"};
  endfunction

  // one reply: en rises, cycles samples, optional mid-run input changes
  task automatic run(input int m, input int d, input int n, input int cycles,
                     input bit perturb, input string extra);
    int p;
    string tag;
    p = e_per(m, d, n);
    @(negedge clk);
    mode = 2'(m);
    dr   = d[0];
    trc  = CNT_W'(n);
    en   = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      int pos, es, est;
      @(posedge clk);
      #1;
      pos = c % p;
      es  = e_sel(m, p, pos);
      est = (pos == 0) ? 1 : 0;
      tag = {mode_tag(m, d), "/R8", extra};
      if (c == 0) tag = {tag, "/R11"};
      if (perturb && c > cycles / 2) tag = {tag, "/R9"};
      check((int'(sel) == es) && (int'(stb) == est), tag,
            int'({stb, sel}), (est << 2) | es);
      if (perturb && c == cycles / 2) begin
        trc  = CNT_W'($urandom_range(1, 4095));
        dr   = ~dr;
        mode = mode + 2'd1;
      end
    end
    en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk);
      #1;
      check(sel == 2'b00 && stb == 1'b0, "R2 idle after drop", int'({stb, sel}), 0);
      trc = CNT_W'($urandom_range(1, 4095));
    end
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    en    = 1'b0;
    trc   = '0;
    dr    = 1'b0;
    mode  = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check(sel == 2'b00 && stb == 1'b0, "R1 during reset", int'({stb, sel}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    trc   = 12'd100;
    mode  = 2'b10;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #1;
      check(sel == 2'b00 && stb == 1'b0, "R1/R2 idle after reset", int'({stb, sel}), 0);
    end

    // directed corner cases
    run(2, 0, 64, 20, 0, " even half-clock");         // t = 8
    run(2, 0, 72, 20, 0, " odd half-clock");          // t = 9, clk cycle
    run(1, 0, 72, 20, 0, " odd unbalanced");          // 5 high, 4 low
    run(0, 0, 72, 20, 0, " balanced");                // h = 5
    run(0, 0, 8, 8, 0, " R5 smallest half");          // h = 1
    run(0, 0, 3, 8, 0, " R5 half clamp");             // h = 0 -> 1
    run(1, 0, 3, 8, 0, " R10 unbalanced clamp");      // t = 0 -> 2
    run(2, 1, 10, 8, 0, " R10 half-clock clamp");     // t = 0 -> 2
    run(2, 1, 200, 20, 0, " odd half-clock 64/3");    // t = 9
    run(1, 1, 200, 20, 0, " odd unbalanced 64/3");    // t = 9
    run(0, 1, 200, 22, 0, " balanced 64/3");          // h = 5
    run(3, 0, 72, 22, 0, " R5 mode 11");              // balanced fallback
    run(2, 1, 4095, 400, 1, " max count");            // t = 192
    run(0, 0, 4095, 520, 0, " max count balanced");   // h = 256

    for (int i = 0; i < 40; i++) begin
      int m, d, n, p;
      m = $urandom_range(0, 3);
      d = $urandom_range(0, 1);
      n = $urandom_range(1, 4095);
      p = e_per(m, d, n);
      run(m, d, n, 2 * p + 3, 1, " random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule